// File: doc/BRIEF.md
# Dual-Channel Phase-Correct PWM Generator

This block produces two pulse-width-modulated outputs from one shared counter. In the default dual-slope mode the counter climbs from zero to a ceiling, turns, and descends back to zero. Each output changes level where the counter crosses that channel's threshold, so the pulses stay centred within the period. A single-slope mode instead wraps the counter from the ceiling straight back to zero. At the same resolution this gives half the period.

The ceiling follows a resolution select of 8, 9 or 10 bits. Each channel compares the counter only against the low bits of its threshold that the selected resolution covers. Threshold updates arrive on a small valid/ready write stream and are parked in a per-channel holding register. The holding value is copied into the working threshold only on the cycle the counter stands at its ceiling, so a pulse is never cut short or doubled mid-period. The write stream never applies back-pressure: `cmp_ready` is held high, and a beat is taken on every cycle that `cmp_valid` is high. Configuration pins are plain levels. Clock division and register-bus decoding are left to the surrounding logic.

Top module: `twin_pwm_core`

## Requirements
- R1: In dual-slope mode, with `run_en` high, the counter moves by one per clock. At or above the ceiling it turns downward, and at zero while descending it turns upward, so it runs 0,1,…,TOP,TOP-1,…,1,0,1,… with a period of 2·TOP cycles.
- R2: `res_sel` 0 gives TOP = 0x0FF, 1 gives 0x1FF, and 2 or 3 give 0x3FF.
- R3: With `single_slope` = 1 the counter runs upward only and goes from TOP (or above) to 0 on the next enabled clock, giving a period of TOP+1 cycles.
- R4: A channel's working threshold is masked to the low 8, 9 or 10 bits set by `res_sel` before it is compared with the counter.
- R5: A beat with `cmp_valid` high writes `cmp_data` to the holding register of channel A when `cmp_chan` = 0 and channel B when `cmp_chan` = 1. On an enabled clock where the counter is at or above TOP, the holding value present before that clock is copied to the working threshold. Otherwise the working threshold does not change.
- R6: Each channel keeps an internal level. In dual-slope mode, a match while ascending drives that level low after the clock, and a match while descending drives it high. With mode code 2'b10 the output pin equals this level.
- R7: Mode code 2'b11 drives the inverse of the level. Codes 2'b00 and 2'b01 hold the output low.
- R8: In single-slope mode a match drives the level low. At counter value 0 without a match the level goes high. A match at 0 takes precedence.
- R9: While `run_en` is low the counter, direction, levels and working thresholds hold. Writes to the holding registers are still taken.
- R10: After reset the counter is 0 and ascending, all thresholds and levels are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter advance enable |
| res_sel | input | SEL_W (2) | Resolution select: 0=8, 1=9, 2/3=10 bits |
| single_slope | input | 1 | 1 = wrap-around counting, 0 = up/down counting |
| mode_a | input | 2 | Output mode of channel A |
| mode_b | input | 2 | Output mode of channel B |
| cmp_valid | input | 1 | Threshold write beat valid |
| cmp_ready | output | 1 | Threshold write ready, always 1 |
| cmp_chan | input | 1 | Target channel of the write: 0 = A, 1 = B |
| cmp_data | input | CNT_W (10) | Threshold value to park |
| count | output | CNT_W (10) | Present counter value |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The bench builds the block with its defaults: an 8-bit base width and three resolution steps. This makes the full 10-bit ceiling reachable, along with the reserved select code that aliases to it. All three ceilings are driven in both slope modes. The thresholds are chosen to land at zero, at the ceiling, and above the active width, so that masking and match-at-zero precedence are exercised. Threshold writes are issued mid-period and while the counter is frozen, which shows that changes take effect only at the ceiling.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  typedef enum logic [1:0] {
    OM_OFF     = 2'b00,
    OM_OFF_ALT = 2'b01,
    OM_CLR_UP  = 2'b10,
    OM_SET_UP  = 2'b11
  } out_mode_e;
endpackage

// File: rtl/pwm_res_decode.sv
module pwm_res_decode #(
  parameter int BASE_W    = 8,
  parameter int RES_STEPS = 3,
  localparam int CNT_W    = BASE_W + RES_STEPS - 1,
  localparam int SEL_W    = (RES_STEPS > 1) ? $clog2(RES_STEPS) : 1
) (
  input  logic [SEL_W-1:0] res_sel,
  output logic [CNT_W-1:0] top
);
  int width_bits;

  always_comb begin
    if (int'(res_sel) >= RES_STEPS) width_bits = BASE_W + RES_STEPS - 1;
    else                            width_bits = BASE_W + int'(res_sel);
    for (int i = 0; i < CNT_W; i++) top[i] = (i < width_bits);
  end
endmodule

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             single_slope,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             going_down,
  output logic             at_ceiling
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_ceiling = run_en && (count >= top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      going_down <= 1'b0;
    end else if (run_en) begin
      if (single_slope) begin
        going_down <= 1'b0;
        count      <= (count >= top) ? '0 : count + ONE;
      end else if (!going_down) begin
        if (count >= top) begin
          going_down <= 1'b1;
          count      <= count - ONE;
        end else begin
          count <= count + ONE;
        end
      end else begin
        if (count == '0) begin
          going_down <= 1'b0;
          count      <= ONE;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] active
);
  logic [CNT_W-1:0] parked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked <= '0;
      active <= '0;
    end else begin
      if (load)  active <= parked;
      if (wr_en) parked <= wr_data;
    end
  end
endmodule

// File: rtl/pwm_wave_unit.sv
module pwm_wave_unit
  import pwmgen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             single_slope,
  input  logic             going_down,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] threshold,
  input  logic [1:0]       mode,
  output logic             pwm
);
  logic level;
  logic hit;
  out_mode_e md;

  assign hit = (count == threshold);
  assign md  = out_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else if (run_en) begin
      if (single_slope) begin
        if (hit)                level <= 1'b0;
        else if (count == '0)   level <= 1'b1;
      end else if (hit) begin
        level <= going_down;
      end
    end
  end

  always_comb begin
    unique case (md)
      OM_CLR_UP: pwm = level;
      OM_SET_UP: pwm = ~level;
      default:   pwm = 1'b0;
    endcase
  end
endmodule

// File: rtl/twin_pwm_core.sv
module twin_pwm_core #(
  parameter int BASE_W    = 8,
  parameter int RES_STEPS = 3,
  localparam int CNT_W    = BASE_W + RES_STEPS - 1,
  localparam int SEL_W    = (RES_STEPS > 1) ? $clog2(RES_STEPS) : 1,
  localparam int NUM_CH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             single_slope,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic             cmp_chan,
  input  logic [CNT_W-1:0] cmp_data,
  output logic [CNT_W-1:0] count,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic [CNT_W-1:0] top_val;
  logic             going_down;
  logic             at_ceiling;
  logic [1:0]       mode_v [NUM_CH];
  logic             pwm_v  [NUM_CH];

  assign cmp_ready = 1'b1;
  assign mode_v[0] = mode_a;
  assign mode_v[1] = mode_b;
  assign pwm_a     = pwm_v[0];
  assign pwm_b     = pwm_v[1];

  pwm_res_decode #(.BASE_W(BASE_W), .RES_STEPS(RES_STEPS)) u_res (
    .res_sel (res_sel),
    .top     (top_val)
  );

  pwm_slope_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .single_slope (single_slope),
    .top          (top_val),
    .count        (count),
    .going_down   (going_down),
    .at_ceiling   (at_ceiling)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] active;
    logic             wr_hit;

    assign wr_hit = cmp_valid && cmp_ready && (int'(cmp_chan) == c);

    pwm_cmp_buffer #(.CNT_W(CNT_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .wr_data (cmp_data),
      .load    (at_ceiling),
      .active  (active)
    );

    pwm_wave_unit #(.CNT_W(CNT_W)) u_wave (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .single_slope (single_slope),
      .going_down   (going_down),
      .count        (count),
      .threshold    (active & top_val),
      .mode         (mode_v[c]),
      .pwm          (pwm_v[c])
    );
  end
endmodule

// File: rtl/twin_pwm_checker.sv
module twin_pwm_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             single_slope,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] top,
  input logic             pwm_a,
  input logic             pwm_b
);
  AST_DUAL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !single_slope && count == '0) |=> (count == CNT_W'(1))); // R1

  AST_DUAL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !single_slope && count == top) |=> (count == $past(top) - CNT_W'(1))); // R1

  AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && single_slope && count == top) |=> (count == '0)); // R3

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en) |=> $stable(count)); // R9

  AST_FROZEN_PWM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && mode_a == $past(mode_a)) |=> (mode_a != $past(mode_a) || $stable(pwm_a))); // R9

  AST_FROZEN_PWM_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && mode_b == $past(mode_b)) |=> (mode_b != $past(mode_b) || $stable(pwm_b))); // R9
endmodule

bind twin_pwm_core twin_pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .single_slope (single_slope),
  .mode_a       (mode_a),
  .mode_b       (mode_b),
  .count        (count),
  .top          (top_val),
  .pwm_a        (pwm_a),
  .pwm_b        (pwm_b)
);

// File: tb/tb_twin_pwm_core.sv
`timescale 1ns/1ps
module tb_twin_pwm_core;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic [1:0]    res_sel = 2'd0;
  logic          single_slope = 1'b0;
  logic [1:0]    mode_a = 2'b00;
  logic [1:0]    mode_b = 2'b00;
  logic          cmp_valid = 1'b0;
  logic          cmp_ready;
  logic          cmp_chan = 1'b0;
  logic [CW-1:0] cmp_data = '0;
  logic [CW-1:0] count;
  logic          pwm_a, pwm_b;

  twin_pwm_core dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .res_sel(res_sel),
    .single_slope(single_slope), .mode_a(mode_a), .mode_b(mode_b),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_chan(cmp_chan),
    .cmp_data(cmp_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    compare_on = 1'b0;
  bit    finished = 1'b0;
  string tag = "R10";

  // behavioural reference
  int m_cnt, m_down;
  int m_park[2], m_act[2], m_lv[2];

  function automatic int top_for(input int sel);
    if (sel == 0) return 255;
    if (sel == 1) return 511;
    return 1023;
  endfunction

  function automatic bit pin_for(input int md, input int lv);
    if (md == 2) return lv[0];
    if (md == 3) return ~lv[0];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0;
      for (int c = 0; c < 2; c++) begin m_park[c] = 0; m_act[c] = 0; m_lv[c] = 0; end
    end else begin
      int tp;
      tp = top_for(int'(res_sel));
      if (run_en) begin
        for (int c = 0; c < 2; c++) begin
          int thr;
          thr = m_act[c] % (tp + 1);
          if (single_slope) begin
            if (m_cnt == thr) m_lv[c] = 0;
            else if (m_cnt == 0) m_lv[c] = 1;
          end else if (m_cnt == thr) begin
            m_lv[c] = m_down;
          end
          if (m_cnt >= tp) m_act[c] = m_park[c];
        end
      end
      if (cmp_valid) m_park[int'(cmp_chan)] = int'(cmp_data);
      if (run_en) begin
        if (single_slope) begin
          m_down = 0;
          m_cnt = (m_cnt >= tp) ? 0 : m_cnt + 1;
        end else if (m_down == 0) begin
          if (m_cnt >= tp) begin m_down = 1; m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_down = 0; m_cnt = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      check(tag, "count", int'(count), m_cnt);
      check(tag, "pwm_a", int'(pwm_a), int'(pin_for(int'(mode_a), m_lv[0])));
      check(tag, "pwm_b", int'(pwm_b), int'(pin_for(int'(mode_b), m_lv[1])));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_cmp(input bit ch, input int val);
    @(posedge clk); #1;
    cmp_valid = 1'b1; cmp_chan = ch; cmp_data = CW'(val);
    @(posedge clk); #1;
    cmp_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check("R10", "count after reset", int'(count), 0);
    check("R10", "pwm_a after reset", int'(pwm_a), 0);
    check("R10", "pwm_b after reset", int'(pwm_b), 0);
    check("R5", "cmp_ready", int'(cmp_ready), 1);
    compare_on = 1'b1;

    tag = "R6";
    mode_a = 2'b10; mode_b = 2'b11;
    write_cmp(1'b0, 100);
    write_cmp(1'b1, 200);
    check("R9", "count frozen while writing", int'(count), 0);
    run_en = 1'b1;
    cycles(255);
    check("R2", "8-bit ceiling reached", int'(count), 255);
    cycles(255);
    check("R1", "back at floor after 2*TOP", int'(count), 0);
    cycles(600);

    tag = "R4";
    write_cmp(1'b0, 'h164);
    write_cmp(1'b1, 'h2FF);
    cycles(1200);

    tag = "R5";
    res_sel = 2'd1;
    for (int k = 0; k < 6; k++) begin
      write_cmp(k[0], 37 * k + 60);
      cycles(170 + 41 * k);
    end
    cycles(1100);

    tag = "R7";
    mode_a = 2'b11; mode_b = 2'b10;
    cycles(700);
    mode_a = 2'b00; mode_b = 2'b01;
    cycles(400);
    check("R7", "off code holds pwm_a low", int'(pwm_a), 0);
    check("R7", "alt off code holds pwm_b low", int'(pwm_b), 0);

    tag = "R8";
    mode_a = 2'b10; mode_b = 2'b11;
    write_cmp(1'b0, 0);
    write_cmp(1'b1, 128);
    single_slope = 1'b1;
    res_sel = 2'd0;
    cycles(1600);

    tag = "R3";
    write_cmp(1'b0, 300);
    res_sel = 2'd1;
    cycles(2000);

    tag = "R2";
    single_slope = 1'b0;
    res_sel = 2'd2;
    write_cmp(1'b0, 700);
    write_cmp(1'b1, 1023);
    cycles(4200);
    res_sel = 2'd3;
    cycles(2200);

    tag = "R9";
    for (int k = 0; k < 8; k++) begin
      run_en = 1'b0;
      write_cmp(k[0], 90 + 111 * k);
      cycles(15 + k);
      run_en = 1'b1;
      cycles(300 + 13 * k);
    end

    tag = "R1";
    res_sel = 2'd0;
    cycles(1500);

    finished = 1'b1;
    compare_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule